// File: doc/BRIEF.md
# Bitmap Framebuffer Pixel Scanner

The scanner walks a one-bit-per-pixel bitmap held in a word-wide video memory and delivers it as a serial pixel stream in raster order. It produces the word address itself, takes the returned word, and shifts its bits out one per clock. Each pixel carries its row and column, plus markers for the first pixel of the frame and the first pixel of each line. The default geometry is 256 rows by 512 columns, stored as 32 words of 16 bits per row in an 8K-word memory.

The memory is read asynchronously: the block drives an address and expects the word at that address on the read-data input in the same cycle. A downstream consumer can pause the stream with the enable input. While enable is low the scanner keeps its position and the bits it still holds. The scan repeats frame after frame with no idle cycles between frames.

Top module: `fb_pixel_scanner`

## Requirements
- R1: While reset is high at a clock edge, and after it is released with enable low, pix_valid, frame_start and line_start are 0 and mem_addr is 0, which is the word for row 0, column 0.
- R2: Before each pixel is emitted, mem_addr equals row*(COLS/WORD_W) + col/WORD_W for that pixel's row and column.
- R3: The pixel at column c is bit (c mod WORD_W) of its word, with bit 0 taken as the leftmost pixel of the group. A 1 means black and a 0 means white.
- R4: When enable is high at a clock edge, one pixel is presented after that edge with pix_valid high. Back-to-back enabled cycles give one pixel per cycle with no gaps, including across word boundaries.
- R5: The column rises by one per emitted pixel. After column COLS-1 the column returns to 0 and the row rises by one.
- R6: After the pixel at row ROWS-1, column COLS-1, the next emitted pixel is row 0, column 0.
- R7: frame_start is high exactly with the pixel at row 0, column 0.
- R8: line_start is high exactly with each pixel at column 0.
- R9: While enable is low, pix_valid, frame_start and line_start are 0, and mem_addr, pix_row and pix_col keep their values. On resume, the stream continues at the next pixel. Bits of a word that was already partly emitted come from the retained copy, even if the memory word changed during the pause. A word whose first pixel has not yet been emitted is read fresh.
- R10: A reset in the middle of a frame makes the next emitted pixel row 0, column 0, with frame_start high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable; one pixel per enabled cycle |
| mem_addr | output | ADDR_W | Video memory word address |
| mem_rdata | input | WORD_W | Word at mem_addr, same cycle |
| pix_valid | output | 1 | A pixel is presented this cycle |
| pix_bit | output | 1 | Pixel value, 1 black, 0 white |
| pix_row | output | clog2(ROWS) | Row of the presented pixel |
| pix_col | output | clog2(COLS) | Column of the presented pixel |
| frame_start | output | 1 | Presented pixel is row 0, column 0 |
| line_start | output | 1 | Presented pixel is column 0 |

## Verification
The bench builds the scanner with ROWS=4, COLS=48, WORD_W=16 and ADDR_W=4. A frame is then 192 pixels over twelve words, so the bench can run several full frames and cross the wrap from the last pixel back to the first more than once. With three words per row, the words per row are not a power of two, so the address must come from a true multiply and add rather than from concatenating the row and word index. The pause cases place a stall in the middle of a word and another exactly on a word boundary, and rewrite memory during each stall, which separates a retained word from a refetched one.

// File: rtl/fb_pixel_scanner.sv
module fb_pixel_scanner #(
  parameter int ROWS   = 256,
  parameter int COLS   = 512,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 13,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              pix_valid,
  output logic              pix_bit,
  output logic [ROW_W-1:0]  pix_row,
  output logic [COL_W-1:0]  pix_col,
  output logic              frame_start,
  output logic              line_start
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int WPR   = COLS / WORD_W;

  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [WORD_W-1:0] sreg_q;

  wire group_head = (col_q[BIT_W-1:0] == '0);
  wire last_col   = (col_q == COL_W'(COLS - 1));
  wire last_row   = (row_q == ROW_W'(ROWS - 1));
  wire [WORD_W-1:0] word = group_head ? mem_rdata : sreg_q;

  // The first bit of a group comes straight from memory; the rest from the shifter.
  assign mem_addr = ADDR_W'(int'(row_q) * WPR + int'(col_q >> BIT_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q       <= '0;
      col_q       <= '0;
      sreg_q      <= '0;
      pix_valid   <= 1'b0;
      pix_bit     <= 1'b0;
      pix_row     <= '0;
      pix_col     <= '0;
      frame_start <= 1'b0;
      line_start  <= 1'b0;
    end else begin
      pix_valid   <= en;
      frame_start <= en && (row_q == '0) && (col_q == '0);
      line_start  <= en && (col_q == '0);
      if (en) begin
        pix_bit <= word[0];
        pix_row <= row_q;
        pix_col <= col_q;
        sreg_q  <= word >> 1;
        col_q   <= last_col ? '0 : col_q + 1'b1;
        if (last_col)
          row_q <= last_row ? '0 : row_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fb_scanner_chk.sv
module fb_scanner_chk #(
  parameter int ROWS   = 256,
  parameter int COLS   = 512,
  parameter int ADDR_W = 13,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              pix_valid,
  input logic [ROW_W-1:0]  pix_row,
  input logic [COL_W-1:0]  pix_col,
  input logic              frame_start,
  input logic              line_start
);
  a_r4_valid_after_en: assert property (@(posedge clk) disable iff (rst)
    en |=> pix_valid);

  a_r9_quiet_when_held: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pix_valid && !frame_start && !line_start));

  a_r9_addr_held: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(mem_addr));

  a_r7_frame_marker: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (pix_valid && pix_row == '0 && pix_col == '0));

  a_r8_line_marker: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && pix_col == '0) |-> line_start);

  a_r5_col_step: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && en && pix_col != COL_W'(COLS - 1)) |=>
      (pix_col == $past(pix_col) + 1'b1 && pix_row == $past(pix_row)));

  a_r6_frame_wrap: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && en && pix_row == ROW_W'(ROWS - 1) && pix_col == COL_W'(COLS - 1))
      |=> frame_start);
endmodule

bind fb_pixel_scanner fb_scanner_chk #(.ROWS(ROWS), .COLS(COLS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .mem_addr(mem_addr), .pix_valid(pix_valid),
  .pix_row(pix_row), .pix_col(pix_col), .frame_start(frame_start), .line_start(line_start)
);

// File: tb/sim_fb_pixel_scanner.sv
module sim_fb_pixel_scanner;
  localparam int ROWS = 4, COLS = 48, WORD_W = 16, ADDR_W = 4;
  localparam int WPR = COLS / WORD_W;
  localparam int ROW_W = $clog2(ROWS), COL_W = $clog2(COLS);

  logic clk = 0, rst = 1, en = 0;
  logic [ADDR_W-1:0] mem_addr;
  logic [WORD_W-1:0] mem_rdata;
  logic pix_valid, pix_bit, frame_start, line_start;
  logic [ROW_W-1:0] pix_row;
  logic [COL_W-1:0] pix_col;
  logic [WORD_W-1:0] mem [16];

  int nchk = 0, nerr = 0;
  int er = 0, ec = 0;
  logic [WORD_W-1:0] shadow = '0;
  bit done = 0;

  always #5 clk = ~clk;
  assign mem_rdata = mem[mem_addr];

  fb_pixel_scanner #(.ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .en(en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .pix_valid(pix_valid), .pix_bit(pix_bit), .pix_row(pix_row), .pix_col(pix_col),
    .frame_start(frame_start), .line_start(line_start));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic fill(int kind);
    for (int i = 0; i < 16; i++)
      mem[i] = (kind == 0) ? WORD_W'((i * 16'h1357) ^ (16'h8001 << (i % 5)))
                           : ((i % 2) ? 16'hAAAA : 16'h0F0F);
  endtask

  // One enabled pixel: check address before the edge, outputs after it.
  task automatic emit_one();
    logic [WORD_W-1:0] w;
    int a = er * WPR + ec / WORD_W;
    chk("R2 addr", 32'(mem_addr), 32'(a));
    if (ec % WORD_W == 0) shadow = mem[a];
    w = shadow;
    tick();
    chk("R4 valid", 32'(pix_valid), 1);
    chk("R3 bit", 32'(pix_bit), 32'(w[ec % WORD_W]));
    chk("R5 row", 32'(pix_row), 32'(er));
    chk("R5 col", 32'(pix_col), 32'(ec));
    chk("R7 frame_start", 32'(frame_start), 32'(er == 0 && ec == 0));
    chk("R8 line_start", 32'(line_start), 32'(ec == 0));
    if (ec == COLS - 1) begin
      ec = 0;
      er = (er == ROWS - 1) ? 0 : er + 1;
    end else ec++;
  endtask

  task automatic t_reset();
    rst = 1; en = 0;
    tick(); tick();
    chk("R1 valid", 32'(pix_valid), 0);
    chk("R1 frame_start", 32'(frame_start), 0);
    rst = 0;
    tick();
    chk("R1 valid idle", 32'(pix_valid), 0);
    chk("R1 line_start", 32'(line_start), 0);
    chk("R1 addr", 32'(mem_addr), 0);
    er = 0; ec = 0;
  endtask

  task automatic t_frames(int kind, int nframes);
    fill(kind);
    en = 1;
    for (int i = 0; i < nframes * ROWS * COLS; i++) begin
      if (i > 0 && er == 0 && ec == 0) chk("R6 wrap", 32'(pix_col), COLS - 1);
      emit_one();
    end
    en = 0;
    tick();
  endtask

  task automatic stall(int cycles, bit poke);
    logic [ADDR_W-1:0] a0 = mem_addr;
    logic [COL_W-1:0] c0 = pix_col;
    en = 0;
    if (poke) mem[a0] = ~mem[a0];
    for (int k = 0; k < cycles; k++) begin
      tick();
      chk("R9 valid low", 32'(pix_valid), 0);
      chk("R9 markers low", 32'({frame_start, line_start}), 0);
      chk("R9 addr held", 32'(mem_addr), 32'(a0));
      chk("R9 col held", 32'(pix_col), 32'(c0));
    end
    en = 1;
  endtask

  task automatic t_stall();
    t_reset();
    fill(0);
    en = 1;
    repeat (5) emit_one();
    stall(3, 1);           // mid-word: retained bits used
    repeat (15) emit_one(); // reaches a word boundary (col 20 -> 32 ... )
    while (ec % WORD_W != 0) emit_one();
    stall(2, 1);           // on a boundary: new word read fresh
    repeat (20) emit_one();
    stall(1, 0);
    for (int i = 0; i < ROWS * COLS; i++) emit_one();
    en = 0;
    tick();
  endtask

  task automatic t_reset_mid();
    fill(1);
    en = 1;
    repeat (70) emit_one();
    rst = 1;
    tick();
    rst = 0;
    er = 0; ec = 0;
    emit_one();
    chk("R10 row", 32'(pix_row), 0);
    chk("R10 col", 32'(pix_col), 0);
    chk("R10 frame_start", 32'(frame_start), 1);
    repeat (60) emit_one();
    en = 0;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    fill(0);
    #1;
    t_reset();
    t_frames(0, 2);
    t_reset();
    t_frames(1, 1);
    t_stall();
    t_reset_mid();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule